// File: doc/BRIEF.md
# Sub-Word Memory Lane Unit

This block sits between a load/store pipeline and a synchronous data memory that is organised in rows. The row is 64 bits wide by default and is a parameter. A request gives a byte address, an access size of 1, 2, 4 or 8 bytes, a load/store flag, a byte-reversal enable and store data.

For a load, the unit reads the row that holds the address. It shifts the addressed lane down to bit 0 and masks it to the access size. If reversal is enabled, it then reverses the byte order within the access size. The result is returned zero-extended to 64 bits.

For a store, the unit first masks the data to the access size and reverses it if asked. It then places the item in its lane. A store of less than a row is done as read-modify-write over two cycles. A full-row store is written in its acceptance cycle.

A request whose address is not a multiple of its size is rejected with a one-cycle error pulse. So is a request wider than the row. With 4-byte rows, the same unit serves instruction fetch as 4-byte loads without reversal.

Top module: `mem_lane_unit`

## Requirements
- R1: After reset, reqReady is 1, and loadValid, alignErr and loadData are all 0.
- R2: An accepted aligned load drives memAddr = reqAddr >> log2(ROW_BYTES) with memRe in its acceptance cycle. On the second rising edge after acceptance, loadValid pulses high for one cycle. At the same time, loadData holds the addressed bytes: the byte at the lowest address is in bits 7:0, and the bits above the access size are zero.
- R3: reqSize encodes the access size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes.
- R4: An aligned store narrower than a row changes only the addressed bytes of the row and keeps all the others. reqReady is 0 in the cycle after acceptance and 1 again in the cycle after that.
- R5: A store whose size equals the row replaces the whole row in its acceptance cycle. reqReady stays 1 in the cycle after acceptance.
- R6: When reqSwap is 1, a load reverses the order of the extracted bytes within the access size. A store reverses the order of the data bytes within the access size before it inserts them. With size 1 byte, reversal has no effect.
- R7: A request whose address offset is not a multiple of its size gives alignErr = 1 for one cycle, in the cycle after acceptance. In that cycle loadData is 0 and loadValid is 0. Memory is not written, and reqReady stays 1.
- R8: A request larger than the row is rejected in the same way as in R7.
- R9: With ROW_BYTES = 4, a 4-byte load without reversal returns the stored 32-bit word. A 2-byte load returns the addressed half-word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can accept a request |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 2 | Access size code (R3) |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqSwap | input | 1 | Reverse byte order within the access size |
| reqWdata | input | 64 | Store data, right-aligned |
| memAddr | output | ADDR_W-log2(ROW_BYTES) | Row index to memory |
| memRe | output | 1 | Row read strobe |
| memWe | output | 1 | Row write strobe |
| memWdata | output | 8*ROW_BYTES | Row write data |
| memRdata | input | 8*ROW_BYTES | Row read data, valid the cycle after memRe |
| loadData | output | 64 | Load result, zero-extended |
| loadValid | output | 1 | Load result valid pulse |
| alignErr | output | 1 | Rejected-request pulse |

## Verification
A wrong captured offset or size shows up one cycle after acceptance. Either loadData carries the wrong lane, or a later load reads back a row whose untouched bytes have changed. A wrong merge mask therefore appears only when the same row is next read. For that reason the bench re-reads whole rows after every narrow or rejected store. A state machine that stays busy, or that is idle too early, shows up at once on reqReady in the cycle after acceptance.

// File: rtl/lane_pkg.sv
package lane_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_MERGE = 2'd2
  } laneState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fromReq;   // use live request fields (acceptance cycle)
    logic capture;   // register request fields
    logic memRe;
    logic memWe;
    logic loadDone;  // extract row into loadData
    logic errSet;    // reject request
  } laneStrobes_t;

  // all ones over the access size in bits
  function automatic logic [63:0] sizeMask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return {64{1'b1}};
    endcase
  endfunction

  // reverse byte order within the access size; bytes above it are zero
  function automatic logic [63:0] revBytes(input logic [63:0] d, input logic [1:0] sz);
    logic [63:0] r;
    int w;
    r = '0;
    w = 1 << sz;
    for (int i = 0; i < 8; i++) begin
      if (i < w) r[8*i +: 8] = d[8*(w-1-i) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqStore,
  input  logic         alignOk,
  input  logic         fullRow,
  output logic         reqReady,
  output laneStrobes_t strb
);

  laneState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    reqReady  = (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.fromReq = 1'b1;
          if (!alignOk) begin
            strb.errSet = 1'b1;
          end else if (!reqStore) begin
            strb.memRe   = 1'b1;
            strb.capture = 1'b1;
            stateNext    = ST_LOAD;
          end else if (fullRow) begin
            strb.memWe = 1'b1;
          end else begin
            strb.memRe   = 1'b1;
            strb.capture = 1'b1;
            stateNext    = ST_MERGE;
          end
        end
      end
      ST_LOAD: begin
        strb.loadDone = 1'b1;
        stateNext     = ST_IDLE;
      end
      ST_MERGE: begin
        strb.memWe = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R2/R4: a row read always leaves one busy cycle behind it
  p_busy_after_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.memRe |=> !reqReady);

  // R7: a rejected request touches no memory strobe
  p_reject_no_access_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && !alignOk) |-> (!strb.memWe && !strb.memRe));

  // R5: a full-row store does not stall
  p_full_store_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && alignOk && reqStore && fullRow) |=> reqReady);

endmodule

// File: rtl/lane_dp.sv
module lane_dp
  import lane_pkg::*;
#(
  parameter int ROW_BYTES = 8,
  parameter int ADDR_W    = 12,
  localparam int OFF_W    = $clog2(ROW_BYTES),
  localparam int ROW_W    = 8 * ROW_BYTES,
  localparam int ROW_AW   = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  laneStrobes_t       strb,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         reqSize,
  input  logic               reqSwap,
  input  logic [63:0]        reqWdata,
  input  logic [ROW_W-1:0]   memRdata,
  output logic [ROW_AW-1:0]  memAddr,
  output logic [ROW_W-1:0]   memWdata,
  output logic               alignOk,
  output logic               fullRow,
  output logic [63:0]        loadData,
  output logic               loadValid,
  output logic               alignErr
);

  logic [OFF_W-1:0]  liveOff, rOff, curOff, lowBits;
  logic [ROW_AW-1:0] liveRow, rRow;
  logic [1:0]        rSize, curSize;
  logic              rSwap, curSwap;
  logic [63:0]       rData, curData, item, extracted, lane;
  logic [ROW_W-1:0]  laneMask, itemRow, baseRow;

  assign liveOff = reqAddr[OFF_W-1:0];
  assign liveRow = reqAddr[ADDR_W-1:OFF_W];

  // alignment: offset must be a multiple of the size, size must fit the row
  always_comb begin
    lowBits = OFF_W'((1 << reqSize) - 1);
    alignOk = (int'(reqSize) <= OFF_W) && ((liveOff & lowBits) == '0);
    fullRow = (int'(reqSize) == OFF_W);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rOff  <= '0;
      rRow  <= '0;
      rSize <= '0;
      rSwap <= 1'b0;
      rData <= '0;
    end else if (strb.capture) begin
      rOff  <= liveOff;
      rRow  <= liveRow;
      rSize <= reqSize;
      rSwap <= reqSwap;
      rData <= reqWdata;
    end
  end

  // store path: size mask, optional reversal, lane insertion
  always_comb begin
    curOff   = strb.fromReq ? liveOff  : rOff;
    curSize  = strb.fromReq ? reqSize  : rSize;
    curSwap  = strb.fromReq ? reqSwap  : rSwap;
    curData  = strb.fromReq ? reqWdata : rData;
    item     = curData & sizeMask(curSize);
    if (curSwap) item = revBytes(item, curSize);
    laneMask = ROW_W'(sizeMask(curSize)) << {curOff, 3'b000};
    itemRow  = ROW_W'(item) << {curOff, 3'b000};
    baseRow  = strb.fromReq ? '0 : memRdata;
    memWdata = (baseRow & ~laneMask) | (itemRow & laneMask);
    memAddr  = strb.fromReq ? liveRow : rRow;
  end

  // load path: lane extraction, then optional reversal
  always_comb begin
    lane      = 64'(memRdata >> {rOff, 3'b000});
    extracted = lane & sizeMask(rSize);
    if (rSwap) extracted = revBytes(extracted, rSize);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadData  <= '0;
      loadValid <= 1'b0;
      alignErr  <= 1'b0;
    end else begin
      loadValid <= strb.loadDone;
      alignErr  <= strb.errSet;
      if (strb.errSet)        loadData <= '0;
      else if (strb.loadDone) loadData <= extracted;
    end
  end

  // R2: load result is a single-cycle pulse
  p_load_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> !loadValid);

  // R7: rejection shows zero data and no load result
  p_err_clears_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> (loadData == '0 && !loadValid));

endmodule

// File: rtl/mem_lane_unit.sv
module mem_lane_unit
  import lane_pkg::*;
#(
  parameter int ROW_BYTES = 8,
  parameter int ADDR_W    = 12,
  localparam int ROW_W    = 8 * ROW_BYTES,
  localparam int ROW_AW   = ADDR_W - $clog2(ROW_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqStore,
  input  logic              reqSwap,
  input  logic [63:0]       reqWdata,
  output logic [ROW_AW-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [ROW_W-1:0]  memWdata,
  input  logic [ROW_W-1:0]  memRdata,
  output logic [63:0]       loadData,
  output logic              loadValid,
  output logic              alignErr
);

  laneStrobes_t strb;
  logic alignOk, fullRow;

  lane_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .alignOk(alignOk), .fullRow(fullRow), .reqReady(reqReady), .strb(strb)
  );

  lane_dp #(.ROW_BYTES(ROW_BYTES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqSwap(reqSwap), .reqWdata(reqWdata), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .alignOk(alignOk), .fullRow(fullRow),
    .loadData(loadData), .loadValid(loadValid), .alignErr(alignErr)
  );

  assign memRe = strb.memRe;
  assign memWe = strb.memWe;

endmodule

// File: tb/sim_mem_lane_unit.sv
`timescale 1ns/1ps
module sim_mem_lane_unit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // 8-byte-row instance
  logic        aValid = 1'b0, aStore = 1'b0, aSwap = 1'b0;
  logic [11:0] aAddr = '0;
  logic [1:0]  aSize = '0;
  logic [63:0] aWdata = '0;
  logic        aReady, aRe, aWe, aLv, aErr;
  logic [8:0]  aMemAddr;
  logic [63:0] aMemW, aMemR, aLd;
  logic [63:0] memA [512];

  mem_lane_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(aValid), .reqReady(aReady), .reqAddr(aAddr),
    .reqSize(aSize), .reqStore(aStore), .reqSwap(aSwap), .reqWdata(aWdata),
    .memAddr(aMemAddr), .memRe(aRe), .memWe(aWe), .memWdata(aMemW), .memRdata(aMemR),
    .loadData(aLd), .loadValid(aLv), .alignErr(aErr)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 512; i++) memA[i] <= '0;
      aMemR <= '0;
    end else begin
      if (aWe) memA[aMemAddr] <= aMemW;
      if (aRe) aMemR <= memA[aMemAddr];
    end
  end

  // 4-byte-row instance (instruction fetch use)
  logic        bValid = 1'b0, bStore = 1'b0;
  logic [9:0]  bAddr = '0;
  logic [1:0]  bSize = '0;
  logic [63:0] bWdata = '0;
  logic        bReady, bRe, bWe, bLv, bErr;
  logic [7:0]  bMemAddr;
  logic [31:0] bMemW, bMemR;
  logic [63:0] bLd;
  logic [31:0] memB [256];

  mem_lane_unit #(.ROW_BYTES(4), .ADDR_W(10)) u1 (
    .clk(clk), .rstN(rstN), .reqValid(bValid), .reqReady(bReady), .reqAddr(bAddr),
    .reqSize(bSize), .reqStore(bStore), .reqSwap(1'b0), .reqWdata(bWdata),
    .memAddr(bMemAddr), .memRe(bRe), .memWe(bWe), .memWdata(bMemW), .memRdata(bMemR),
    .loadData(bLd), .loadValid(bLv), .alignErr(bErr)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) memB[i] <= '0;
      bMemR <= '0;
    end else begin
      if (bWe) memB[bMemAddr] <= bMemW;
      if (bRe) bMemR <= memB[bMemAddr];
    end
  end

  // byte-level reference image of the 8-byte-row memory
  logic [7:0] refMem [4096];
  initial for (int i = 0; i < 4096; i++) refMem[i] = 8'h00;

  function automatic logic [63:0] refLoad(input int addr, input int sz, input bit swp);
    logic [63:0] v = '0;
    int w = 1 << sz;
    for (int i = 0; i < w; i++)
      v[8*i +: 8] = swp ? refMem[addr + w - 1 - i] : refMem[addr + i];
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // drive at negedge, accept at posedge, release at next negedge
  task automatic sendA(input int addr, input int sz, input bit st, input bit swp, input logic [63:0] d);
    @(negedge clk);
    aAddr = 12'(addr); aSize = 2'(sz); aStore = st; aSwap = swp; aWdata = d; aValid = 1'b1;
    check(aReady == 1'b1, "R2 ready before request", 64'(aReady), 64'd1);
    @(posedge clk);
    @(negedge clk);
    aValid = 1'b0;
  endtask

  task automatic loadA(input int addr, input int sz, input bit swp, input string tag);
    logic [63:0] exp;
    exp = refLoad(addr, sz, swp);
    sendA(addr, sz, 1'b0, swp, '0);
    check(aReady == 1'b0, {tag, " busy after load accept"}, 64'(aReady), 64'd0);
    @(negedge clk);
    check(aLv == 1'b1, {tag, " loadValid"}, 64'(aLv), 64'd1);
    check(aLd == exp, {tag, " loadData"}, aLd, exp);
    @(negedge clk);
    check(aLv == 1'b0, "R2 loadValid single pulse", 64'(aLv), 64'd0);
  endtask

  task automatic storeA(input int addr, input int sz, input bit swp, input logic [63:0] d, input string tag);
    int w = 1 << sz;
    for (int i = 0; i < w; i++)
      refMem[addr + i] = swp ? d[8*(w-1-i) +: 8] : d[8*i +: 8];
    sendA(addr, sz, 1'b1, swp, d);
    if (sz == 3) begin
      check(aReady == 1'b1, "R5 full-row store no stall", 64'(aReady), 64'd1);
    end else begin
      check(aReady == 1'b0, "R4 narrow store busy", 64'(aReady), 64'd0);
      @(negedge clk);
      check(aReady == 1'b1, "R4 ready after merge", 64'(aReady), 64'd1);
    end
    // full-row readback: untouched bytes must survive
    loadA(addr & ~7, 3, 1'b0, tag);
  endtask

  task automatic rejectA(input int addr, input int sz, input bit st, input string tag);
    sendA(addr, sz, st, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    check(aErr == 1'b1, {tag, " alignErr"}, 64'(aErr), 64'd1);
    check(aLd == 64'd0, {tag, " zero data"}, aLd, 64'd0);
    check(aLv == 1'b0, {tag, " no loadValid"}, 64'(aLv), 64'd0);
    check(aReady == 1'b1, {tag, " no stall"}, 64'(aReady), 64'd1);
    @(negedge clk);
    check(aErr == 1'b0, {tag, " one-cycle pulse"}, 64'(aErr), 64'd0);
    loadA(addr & ~7, 3, 1'b0, {tag, " row unchanged"});
  endtask

  task automatic testReset();
    check(aReady == 1'b1, "R1 reqReady", 64'(aReady), 64'd1);
    check(aLv == 1'b0, "R1 loadValid", 64'(aLv), 64'd0);
    check(aErr == 1'b0, "R1 alignErr", 64'(aErr), 64'd0);
    check(aLd == 64'd0, "R1 loadData", aLd, 64'd0);
  endtask

  task automatic testLoads();
    loadA(12'h040, 3, 1'b0, "R2 unwritten row");
    storeA(12'h040, 3, 1'b0, 64'h1122_3344_5566_7788, "R5 full store");
    loadA(12'h043, 0, 1'b0, "R3 size0 byte");
    loadA(12'h046, 1, 1'b0, "R3 size1 half");
    loadA(12'h044, 2, 1'b0, "R3 size2 word");
    loadA(12'h040, 3, 1'b0, "R3 size3 row");
  endtask

  task automatic testNarrowStores();
    storeA(12'h042, 1, 1'b0, 64'hFFFF_FFFF_FFFF_ABCD, "R4 half store");
    storeA(12'h047, 0, 1'b0, 64'h0000_0000_0000_00E1, "R4 top lane byte");
    storeA(12'h040, 0, 1'b0, 64'h0000_0000_0000_0099, "R4 bottom lane byte");
  endtask

  task automatic testSwap();
    loadA(12'h040, 2, 1'b1, "R6 swapped word load");
    loadA(12'h044, 1, 1'b1, "R6 swapped half load");
    loadA(12'h043, 0, 1'b1, "R6 swapped byte load");
    storeA(12'h048, 2, 1'b1, 64'h0000_0000_DEAD_BEEF, "R6 swapped word store");
    loadA(12'h04C, 2, 1'b0, "R6 plain word after swap store");
    storeA(12'h050, 3, 1'b1, 64'h0102_0304_0506_0708, "R6 swapped row store");
  endtask

  task automatic testReject();
    rejectA(12'h041, 1, 1'b0, "R7 odd half load");
    rejectA(12'h044, 3, 1'b1, "R7 misaligned row store");
    rejectA(12'h042, 2, 1'b1, "R7 misaligned word store");
  endtask

  task automatic sendB(input int addr, input int sz, input bit st, input logic [63:0] d);
    @(negedge clk);
    bAddr = 10'(addr); bSize = 2'(sz); bStore = st; bWdata = d; bValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bValid = 1'b0;
  endtask

  task automatic testFetch();
    sendB(10'h010, 2, 1'b1, 64'h0000_0000_1357_9BDF);
    check(bReady == 1'b1, "R9 4-byte row full store", 64'(bReady), 64'd1);
    sendB(10'h010, 2, 1'b0, '0);
    @(negedge clk);
    check(bLv == 1'b1, "R9 fetch valid", 64'(bLv), 64'd1);
    check(bLd == 64'h0000_0000_1357_9BDF, "R9 fetch word", bLd, 64'h1357_9BDF);
    sendB(10'h012, 1, 1'b0, '0);
    @(negedge clk);
    check(bLd == 64'h0000_0000_0000_1357, "R9 fetch half", bLd, 64'h1357);
    sendB(10'h010, 3, 1'b0, '0);
    check(bErr == 1'b1, "R8 size above row rejected", 64'(bErr), 64'd1);
    check(bLd == 64'd0, "R8 rejected zero data", bLd, 64'd0);
    sendB(10'h010, 3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    check(bErr == 1'b1, "R8 oversize store rejected", 64'(bErr), 64'd1);
    sendB(10'h010, 2, 1'b0, '0);
    @(negedge clk);
    check(bLd == 64'h0000_0000_1357_9BDF, "R8 row kept after oversize store", bLd, 64'h1357_9BDF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoads();
    testNarrowStores();
    testSwap();
    testReject();
    testFetch();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1-run stalled actual=timeout expected=completion");
    finishRun();
  end

endmodule